// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host side of a two-wire debug link. Each `start` strobe runs one complete register access towards a debug target. The access has four parts: an 8-bit request header, a line turnaround, a 3-bit acknowledge from the target, and then a data phase that depends on the acknowledge. The engine drives the serial clock and the data line's output and enable. It samples the returned line and hands back the read word, a result code, a parity-error flag and a one-cycle `done` pulse.

The engine carries out every acknowledge path by itself. After OK it moves 32 data bits plus parity and then adds a chosen number of low idle cycles. After WAIT or FAULT it can run a dummy data phase so the target's state machine stays in step. For any other acknowledge it backs off for a full data-phase length. A free-running counter can be latched at the end of a successful data phase to stamp the access. The serial clock runs either at one system clock per half period or at a programmable slower rate. All configuration is latched on `start`.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is driven LSB first, one bit per serial clock period. Its bit order is: start=1, req[0] (port select), req[1] (read flag), req[2], req[3], even parity of req[3:0], stop=0, park=1. The data line and its enable change only while the serial clock is low.
- R2: After the header, the driver is released (`swdio_oe`=0) for cfg_trn+1 serial clock periods before the acknowledge.
- R3: The acknowledge is three released bits, sampled on the rising serial clock, with the first bit as bit 0. OK=3'b001, WAIT=3'b010, FAULT=3'b100. The code is reported on `ack_o` with `done`.
- R4: On an OK read, 32 data bits (first bit = bit 0) and a parity bit are captured while the line is released. Then cfg_trn+1 released periods follow. `rdata` holds the word. If the parity is not even, `ack_o`=3'b000 and `par_err`=1.
- R5: On an OK write, cfg_trn+1 released periods come first. Then the engine drives `wdata` (bit 0 first) followed by its even parity.
- R6: After an OK access, cfg_idle periods follow with the line driven low. With cfg_idle=0 there are none.
- R7: On WAIT or FAULT with `cfg_dphase`=1, a read gets 33 released periods before the cfg_trn+1 released periods. A write gets the turnaround and then 33 periods driven low. With `cfg_dphase`=0 only the turnaround follows.
- R8: Any other acknowledge gives cfg_trn+34 released periods, then returns the raw code with `par_err`=0.
- R9: Between accesses the serial clock is high and the line is driven high. `done` is a single-cycle pulse, once per access.
- R10: With `cfg_fast`=1 each serial clock half period lasts one system clock. Otherwise it lasts cfg_dly+1 system clocks.
- R11: With `ts_req`=1 and an OK acknowledge, `ts_o` takes the free-running cycle counter's value at the end of the data phase. Otherwise `ts_o` keeps its value.
- R12: `start` during an access is ignored. Request, data and configuration are taken only in the cycle `start` is accepted.
- R13: During reset the serial clock is high, the line is driven high, and `done`, `ack_o` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one access (accepted when idle) |
| req | input | 4 | {A3, A2, read flag, port select} |
| ts_req | input | 1 | Latch timestamp on a successful access |
| wdata | input | 32 | Write word |
| cfg_trn | input | TRN_W | Turnaround length minus one |
| cfg_idle | input | IDLE_W | Trailing idle periods after OK |
| cfg_dphase | input | 1 | Run dummy data phase on WAIT/FAULT |
| cfg_fast | input | 1 | Select fastest serial clock |
| cfg_dly | input | DLY_W | Slow half period minus one, in clocks |
| swclk | output | 1 | Serial clock pin |
| swdio_out | output | 1 | Data line output value |
| swdio_in | input | 1 | Data line input value |
| swdio_oe | output | 1 | Data line driver enable |
| rdata | output | 32 | Captured read word |
| ack_o | output | 3 | Result code |
| par_err | output | 1 | Read parity mismatch |
| ts_o | output | TS_W | Latched timestamp |
| done | output | 1 | Access complete pulse |

## Verification
Some properties are checked on every cycle. The line and driver enable stay still while the serial clock is high inside an access. The idle line is high with the clock high. `done` never lasts two cycles. A parity error always carries the 3'b000 code. `start` during an access leaves the latched request alone. The half-period counter stays within its limit. Only the bench scenarios show the bit-by-bit sequences of each acknowledge path, the turnaround and idle lengths, the clock period for both rates, the timestamp window, and that inputs changed after `start` have no effect.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_TRN1, ST_ACK, ST_RDAT, ST_TRN2, ST_TRNW,
    ST_WDAT, ST_IDLC, ST_DUMR, ST_DUMW, ST_BACK, ST_FIN
  } swd_st_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [2:0] ACK_PERR  = 3'b000;

  localparam int HDR_BITS = 8;
  localparam int ACK_BITS = 3;
  localparam int DAT_BITS = 32;
  localparam int DPH_BITS = DAT_BITS + 1;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast,
  input  logic [DLY_W-1:0] dly,
  output logic             swclk,
  output logic             smp_stb,
  output logic             bit_end
);
  logic [DLY_W-1:0] hcnt_q, hcnt_d, lim;
  logic             ph_q, ph_d, half_done;

  // ph_q = 0: clock low half, ph_q = 1: clock high half
  always_comb begin
    lim       = fast ? '0 : dly;
    half_done = run && (hcnt_q == lim);
    hcnt_d    = hcnt_q;
    ph_d      = ph_q;
    if (!run) begin
      hcnt_d = '0;
      ph_d   = 1'b0;
    end else if (half_done) begin
      hcnt_d = '0;
      ph_d   = ~ph_q;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      ph_q   <= ph_d;
    end
  end

  assign smp_stb = half_done & ~ph_q;
  assign bit_end = half_done & ph_q;
  assign swclk   = ~(run & ~ph_q);

  p_hcnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt_q <= lim));
endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture
  import swd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ack_stb,
  input  logic                dat_stb,
  input  logic [5:0]          idx,
  input  logic                din,
  output logic [2:0]          ack_raw,
  output logic [DAT_BITS-1:0] rdata,
  output logic                par_bad
);
  logic [2:0]          ack_q, ack_d;
  logic [DAT_BITS-1:0] rd_q, rd_d;
  logic                acc_q, acc_d, bad_q, bad_d;

  always_comb begin
    ack_d = ack_q;
    rd_d  = rd_q;
    acc_d = acc_q;
    bad_d = bad_q;
    if (clr) begin
      ack_d = '0;
      acc_d = 1'b0;
      bad_d = 1'b0;
    end else begin
      if (ack_stb) ack_d[idx[1:0]] = din;
      if (dat_stb) begin
        if (idx < 6'(DAT_BITS)) begin
          rd_d  = {din, rd_q[DAT_BITS-1:1]};
          acc_d = acc_q ^ din;
        end else begin
          bad_d = acc_q ^ din;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      rd_q  <= '0;
      acc_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      rd_q  <= rd_d;
      acc_q <= acc_d;
      bad_q <= bad_d;
    end
  end

  assign ack_raw = ack_q;
  assign rdata   = rd_q;
  assign par_bad = bad_q;

  p_ack_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (idx < 6'(ACK_BITS)));
  p_dat_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb |-> (idx <= 6'(DAT_BITS)));
endmodule

// File: rtl/swd_stamp.sv
module swd_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] cnt_q, cnt_d, ts_q, ts_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    ts_d  = latch ? cnt_q : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ts_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ts_q  <= ts_d;
    end
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_pkg::*;
#(
  parameter int TRN_W  = 2,
  parameter int IDLE_W = 8,
  parameter int DLY_W  = 8,
  parameter int TS_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          req,
  input  logic                ts_req,
  input  logic [DAT_BITS-1:0] wdata,
  input  logic [TRN_W-1:0]    cfg_trn,
  input  logic [IDLE_W-1:0]   cfg_idle,
  input  logic                cfg_dphase,
  input  logic                cfg_fast,
  input  logic [DLY_W-1:0]    cfg_dly,
  output logic                swclk,
  output logic                swdio_out,
  input  logic                swdio_in,
  output logic                swdio_oe,
  output logic [DAT_BITS-1:0] rdata,
  output logic [2:0]          ack_o,
  output logic                par_err,
  output logic [TS_W-1:0]     ts_o,
  output logic                done
);
  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  swd_st_e            st_q, st_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d, seg_len, trn_len;
  logic [3:0]         req_q;
  logic [DAT_BITS-1:0] wdata_q;
  logic               tsf_q, dph_q, fast_q;
  logic [TRN_W-1:0]   trn_q;
  logic [IDLE_W-1:0]  idle_q;
  logic [DLY_W-1:0]   dly_q;
  logic [2:0]         ack_q;
  logic               perr_q, done_q;

  logic run, busy, cap_en, smp_stb, bit_end, seg_last;
  logic [2:0] ack_raw;
  logic par_bad, ack_ok, ack_wf, perr_cond, ts_latch, rnw;
  logic [HDR_BITS-1:0] hdr;

  assign busy   = (st_q != ST_IDLE);
  assign run    = busy && (st_q != ST_FIN);
  assign cap_en = (st_q == ST_IDLE) && start;
  assign rnw    = req_q[1];
  assign ack_ok = (ack_raw == ACK_OK);
  assign ack_wf = (ack_raw == ACK_WAIT) || (ack_raw == ACK_FAULT);
  assign hdr    = {1'b1, 1'b0, ^req_q, req_q[3], req_q[2], req_q[1], req_q[0], 1'b1};
  assign trn_len = CNT_W'(trn_q) + 1'b1;

  swd_bit_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_s), .run(run), .fast(fast_q), .dly(dly_q),
    .swclk(swclk), .smp_stb(smp_stb), .bit_end(bit_end)
  );

  swd_rx_capture u_rx (
    .clk(clk), .rst_n(rst_s), .clr(cap_en),
    .ack_stb(smp_stb && (st_q == ST_ACK)),
    .dat_stb(smp_stb && (st_q == ST_RDAT)),
    .idx(bcnt_q[5:0]), .din(swdio_in),
    .ack_raw(ack_raw), .rdata(rdata), .par_bad(par_bad)
  );

  swd_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_s), .latch(ts_latch), .ts_o(ts_o)
  );

  // length of the current segment in serial clock periods
  always_comb begin
    case (st_q)
      ST_HDR:                      seg_len = CNT_W'(HDR_BITS);
      ST_TRN1, ST_TRN2, ST_TRNW:   seg_len = trn_len;
      ST_ACK:                      seg_len = CNT_W'(ACK_BITS);
      ST_RDAT, ST_WDAT,
      ST_DUMR, ST_DUMW:            seg_len = CNT_W'(DPH_BITS);
      ST_IDLC:                     seg_len = CNT_W'(idle_q);
      ST_BACK:                     seg_len = trn_len + CNT_W'(DPH_BITS);
      default:                     seg_len = CNT_W'(1);
    endcase
    seg_last = bit_end && (bcnt_q == seg_len - 1'b1);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_HDR;
      ST_FIN:  st_d = ST_IDLE;
      default: if (seg_last) begin
        case (st_q)
          ST_HDR:  st_d = ST_TRN1;
          ST_TRN1: st_d = ST_ACK;
          ST_ACK: begin
            if (ack_ok)      st_d = rnw ? ST_RDAT : ST_TRNW;
            else if (ack_wf) st_d = (rnw && dph_q) ? ST_DUMR : ST_TRN2;
            else             st_d = ST_BACK;
          end
          ST_RDAT: st_d = ST_TRN2;
          ST_DUMR: st_d = ST_TRN2;
          ST_TRN2: begin
            if (ack_ok)               st_d = (idle_q != '0) ? ST_IDLC : ST_FIN;
            else if (!rnw && dph_q)   st_d = ST_DUMW;
            else                      st_d = ST_FIN;
          end
          ST_TRNW: st_d = ST_WDAT;
          ST_WDAT: st_d = (idle_q != '0) ? ST_IDLC : ST_FIN;
          default: st_d = ST_FIN;
        endcase
      end
    endcase
    if (cap_en)       bcnt_d = '0;
    else if (bit_end) bcnt_d = seg_last ? '0 : bcnt_q + 1'b1;
    else              bcnt_d = bcnt_q;
  end

  // line drive per state
  always_comb begin
    swdio_oe  = 1'b0;
    swdio_out = 1'b1;
    case (st_q)
      ST_IDLE, ST_FIN: swdio_oe = 1'b1;
      ST_HDR: begin
        swdio_oe  = 1'b1;
        swdio_out = hdr[bcnt_q[2:0]];
      end
      ST_WDAT: begin
        swdio_oe  = 1'b1;
        swdio_out = (bcnt_q < CNT_W'(DAT_BITS)) ? wdata_q[bcnt_q[4:0]] : ^wdata_q;
      end
      ST_IDLC, ST_DUMW: begin
        swdio_oe  = 1'b1;
        swdio_out = 1'b0;
      end
      default: ;
    endcase
  end

  assign perr_cond = ack_ok && rnw && par_bad;
  assign ts_latch  = seg_last && tsf_q && ((st_q == ST_RDAT) || (st_q == ST_WDAT));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      bcnt_q  <= '0;
      req_q   <= '0;
      wdata_q <= '0;
      tsf_q   <= 1'b0;
      dph_q   <= 1'b0;
      fast_q  <= 1'b0;
      trn_q   <= '0;
      idle_q  <= '0;
      dly_q   <= '0;
      ack_q   <= '0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      done_q <= (st_q == ST_FIN);
      if (cap_en) begin
        req_q   <= req;
        wdata_q <= wdata;
        tsf_q   <= ts_req;
        dph_q   <= cfg_dphase;
        fast_q  <= cfg_fast;
        trn_q   <= cfg_trn;
        idle_q  <= cfg_idle;
        dly_q   <= cfg_dly;
      end
      if (st_q == ST_FIN) begin
        ack_q  <= perr_cond ? ACK_PERR : ack_raw;
        perr_q <= perr_cond;
      end
    end
  end

  assign ack_o   = ack_q;
  assign par_err = perr_q;
  assign done    = done_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE) |-> (swclk && swdio_oe && swdio_out));
  p_hi_stable_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (run && $past(run) && swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));
  p_perr_code_r4: assert property (@(posedge clk) disable iff (!rst_s)
    par_err |-> (ack_o == ACK_PERR));
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start) |=> $stable(req_q));
endmodule

// File: tb/tb_swd_xfer_engine.sv
module tb_swd_xfer_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, ts_req, cfg_dphase, cfg_fast, swdio_in;
  logic [3:0]  req;
  logic [31:0] wdata, rdata, ts_o;
  logic [1:0]  cfg_trn;
  logic [7:0]  cfg_idle, cfg_dly;
  logic        swclk, swdio_out, swdio_oe, par_err, done;
  logic [2:0]  ack_o;

  swd_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .ts_req(ts_req),
    .wdata(wdata), .cfg_trn(cfg_trn), .cfg_idle(cfg_idle), .cfg_dphase(cfg_dphase),
    .cfg_fast(cfg_fast), .cfg_dly(cfg_dly), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_in(swdio_in), .swdio_oe(swdio_oe), .rdata(rdata), .ack_o(ack_o),
    .par_err(par_err), .ts_o(ts_o), .done(done)
  );

  int checks = 0, fails = 0, cyc = 0, idx = 0, base = 0, done_total = 0, rel_in;
  bit finished = 0;
  logic prev_clk = 1'b1;
  bit resp [0:1023];
  bit eo [0:1023];
  bit ev [0:1023];
  int eq [0:1023];
  bit ro [0:1023];
  bit rv [0:1023];
  int rt [0:1023];
  int elen;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // target side: record each rising serial clock, count done pulses
  always @(negedge clk) begin
    int rel;
    if (swclk && !prev_clk) begin
      rel = idx - base;
      if (rel >= 0 && rel < 1024) begin
        ro[rel] = swdio_oe;
        rv[rel] = swdio_out;
        rt[rel] = cyc;
      end
      idx = idx + 1;
    end
    prev_clk = swclk;
    if (done) done_total = done_total + 1;
  end

  always @* begin
    rel_in = idx - base;
    swdio_in = (rel_in >= 0 && rel_in < 1024) ? resp[rel_in] : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagname(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void push(input bit oe, input bit v, input int r);
    eo[elen] = oe;
    ev[elen] = v;
    eq[elen] = r;
    elen++;
  endfunction

  task automatic xfer(input logic [3:0] rq, input logic [31:0] wd, input bit tsf,
                      input int trn, input int idl, input bit dph, input bit fst,
                      input int dl, input logic [2:0] ak, input logic [31:0] rd,
                      input bit badp, input bit poke);
    logic [7:0] hb;
    bit ok, wf;
    int tl, n, d0, t0, mism, mk;
    logic [31:0] ts_before;
    logic [2:0] eack;
    bit eperr;
    for (int i = 0; i < 1024; i++) resp[i] = 1'($urandom);
    elen = 0;
    hb = {1'b1, 1'b0, ^rq, rq[3], rq[2], rq[1], rq[0], 1'b1};
    for (int i = 0; i < 8; i++) push(1, hb[i], 1);           // R1 header
    tl = trn + 1;
    for (int i = 0; i < tl; i++) push(0, 1, 2);              // R2 turnaround
    for (int i = 0; i < 3; i++) begin resp[elen] = ak[i]; push(0, 1, 3); end // R3
    ok = (ak == 3'b001);
    wf = (ak == 3'b010) || (ak == 3'b100);
    if (ok) begin
      if (rq[1]) begin                                        // R4 read
        for (int i = 0; i < 32; i++) begin resp[elen] = rd[i]; push(0, 1, 4); end
        resp[elen] = (^rd) ^ badp; push(0, 1, 4);
        for (int i = 0; i < tl; i++) push(0, 1, 4);
      end else begin                                          // R5 write
        for (int i = 0; i < tl; i++) push(0, 1, 5);
        for (int i = 0; i < 32; i++) push(1, wd[i], 5);
        push(1, ^wd, 5);
      end
      for (int i = 0; i < idl; i++) push(1, 0, 6);            // R6 idle
    end else if (wf) begin                                    // R7
      if (rq[1] && dph) for (int i = 0; i < 33; i++) push(0, 1, 7);
      for (int i = 0; i < tl; i++) push(0, 1, 7);
      if (!rq[1] && dph) for (int i = 0; i < 33; i++) push(1, 0, 7);
    end else begin                                            // R8 back-off
      for (int i = 0; i < tl + 33; i++) push(0, 1, 8);
    end
    eperr = ok && rq[1] && badp;
    eack  = eperr ? 3'b000 : ak;

    @(negedge clk);
    req = rq; wdata = wd; ts_req = tsf; cfg_trn = 2'(trn); cfg_idle = 8'(idl);
    cfg_dphase = dph; cfg_fast = fst; cfg_dly = 8'(dl);
    start = 1'b1; base = idx; d0 = done_total; t0 = cyc; ts_before = ts_o;
    @(negedge clk);
    start = 1'b0;
    // R12: inputs changed after acceptance must not matter
    req = ~rq; wdata = ~wd; ts_req = ~tsf; cfg_trn = ~cfg_trn; cfg_idle = 8'(idl + 7);
    cfg_dphase = ~dph; cfg_fast = ~fst; cfg_dly = 8'(dl + 3);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = (poke && n == 10);
    end
    start = 1'b0;
    chk(done, "R9", "done seen", done, 1);
    chk(ack_o == eack, "R3", "ack code", ack_o, eack);
    chk(par_err == eperr, "R4", "parity flag", par_err, eperr);
    if (ok && rq[1]) chk(rdata == rd, "R4", "read word", rdata, rd);
    chk(swclk && swdio_oe && swdio_out, "R9", "idle line",
        {swclk, swdio_oe, swdio_out}, 3'b111);
    chk((idx - base) == elen, poke ? "R12" : "R1", "bit count", idx - base, elen);
    for (int r = 1; r <= 8; r++) begin
      mism = 0; mk = -1;
      for (int k = 0; k < elen; k++)
        if (eq[k] == r && (ro[k] != eo[k] || (eo[k] && rv[k] != ev[k]))) begin
          mism++; if (mk < 0) mk = k;
        end
      for (int k = 0; k < elen; k++)
        if (eq[k] == r) begin
          chk(mism == 0, tagname(r), $sformatf("line bits (first bad %0d)", mk),
              mk < 0 ? 0 : {ro[mk], rv[mk]}, mk < 0 ? 0 : {eo[mk], ev[mk]});
          break;
        end
    end
    if (elen >= 2)
      chk(rt[1] - rt[0] == 2 * (fst ? 1 : dl + 1), "R10", "period",
          rt[1] - rt[0], 2 * (fst ? 1 : dl + 1));
    if (tsf && ok)
      chk(longint'(ts_o) >= longint'(t0 - 4) && longint'(ts_o) <= longint'(cyc),
          "R11", "stamp window", ts_o, t0);
    else
      chk(ts_o == ts_before, "R11", "stamp held", ts_o, ts_before);
    repeat (3) @(negedge clk);
    chk(done_total - d0 == 1 && !done, "R9", "single done", done_total - d0, 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [2:0] perr_codes [0:4];
    void'($urandom(32'd7151));
    perr_codes[0] = 3'b000; perr_codes[1] = 3'b011; perr_codes[2] = 3'b101;
    perr_codes[3] = 3'b110; perr_codes[4] = 3'b111;
    rst_n = 1'b0; start = 1'b0; req = '0; wdata = '0; ts_req = 1'b0; cfg_trn = '0;
    cfg_idle = '0; cfg_dphase = 1'b0; cfg_fast = 1'b1; cfg_dly = '0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(swclk && swdio_oe && swdio_out, "R13", "reset line", {swclk, swdio_oe, swdio_out}, 3'b111);
    chk(!done && ack_o == 3'b000 && !par_err, "R13", "reset outputs", {done, ack_o, par_err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    xfer(4'b0110, 32'h0, 1, 0, 0, 0, 1, 0, 3'b001, 32'h1234_5678, 0, 0); // OK read
    xfer(4'b1001, 32'hDEAD_BEEF, 1, 1, 3, 0, 0, 2, 3'b001, 32'h0, 0, 0); // OK write slow
    xfer(4'b0010, 32'h0, 0, 2, 1, 0, 1, 0, 3'b001, 32'hA5A5_0F0F, 1, 0); // R4 bad parity
    xfer(4'b0111, 32'h0, 1, 0, 2, 1, 1, 0, 3'b010, 32'h0, 0, 0); // R7 WAIT read dummy
    xfer(4'b1100, 32'h55AA_55AA, 0, 3, 0, 1, 0, 1, 3'b010, 32'h0, 0, 0); // R7 WAIT write dummy
    xfer(4'b0011, 32'h0, 0, 1, 0, 0, 1, 0, 3'b100, 32'h0, 0, 0); // R7 FAULT no dummy
    xfer(4'b0000, 32'h1, 1, 0, 0, 0, 1, 0, 3'b100, 32'h0, 0, 0); // R11 hold on FAULT
    xfer(4'b1010, 32'h0, 0, 3, 0, 1, 1, 0, 3'b111, 32'h0, 0, 0); // R8 protocol error
    xfer(4'b0001, 32'h0, 0, 0, 0, 1, 0, 3, 3'b000, 32'h0, 0, 0); // R8 no response
    xfer(4'b0101, 32'hFFFF_0000, 0, 0, 255, 0, 1, 0, 3'b001, 32'h0, 0, 0); // R6 long idle
    xfer(4'b0110, 32'h0, 0, 1, 4, 0, 1, 0, 3'b001, 32'h8000_0001, 0, 1); // R12 start while busy

    for (int t = 0; t < 40; t++) begin
      int sel;
      logic [2:0] ak;
      sel = int'($urandom % 10);
      if (sel < 6)       ak = 3'b001;
      else if (sel == 6) ak = 3'b010;
      else if (sel == 7) ak = 3'b100;
      else               ak = perr_codes[$urandom % 5];
      xfer(4'($urandom), $urandom, 1'($urandom), int'($urandom % 4), int'($urandom % 13),
           1'($urandom), 1'($urandom), int'($urandom % 4), ak, $urandom,
           ($urandom % 5) == 0, ($urandom % 8) == 0);
    end
    summary();
  end
endmodule